// File: doc/BRIEF.md
# Triggered Multi-Channel Byte Mover

This block is a small direct memory access engine with a parameterised number of channels (four by default, up to eight). Each channel copies bytes from a source address to a destination address inside one flat byte-addressed space. That space is reached through a single synchronous memory port. The port has a request, a write enable, an address, write data and read data, and read data returns in the cycle after a read request. Any address on the port may serve as a source or as a destination.

Software sets up a channel through a write-only configuration port. It selects a channel and a field, then writes a source address, a destination address, a byte count or a control word. A further field acts as a software start. The control word picks one of two modes. In per-byte mode each start moves one byte. In block mode one start moves every byte still counted. The control word can also let a rising edge on one chosen interrupt line start the channel.

A single shared engine moves one byte at a time. In `ENG_IDLE` it grants the lowest-numbered channel that has work and moves to `ENG_READ`. `ENG_READ` issues the read and always moves to `ENG_HOLD`. `ENG_HOLD` captures the returned byte and always moves to `ENG_WRITE`. `ENG_WRITE` issues the write and always returns to `ENG_IDLE`. When no channel has work, the engine stays in `ENG_IDLE`. Each channel reports completion through a sticky flag and a one-cycle pulse.

Top module: `dma_mover`

## Requirements
- R1: After reset `mem_req`, `mem_we`, `done_flag` and `done_pulse` are all low and no channel has work.
- R2: A configuration write in cycle k, with `cfg_we`=1, `cfg_ch` selecting the channel and `cfg_fld` selecting the field, takes effect at the end of cycle k. The field codes are: 0 = source address, 1 = destination address, 2 = byte count (low 8 bits of `cfg_wdata`), 3 = control and 4 = software start (data ignored). The control word has bit 0 = block mode, bit 1 = interrupt start enable and bits 4:2 = interrupt line index.
- R3: Each byte move takes four cycles. The first is an arbitration cycle with no request. Next comes a read cycle with `mem_req`=1, `mem_we`=0 and `mem_addr` set to the source. Then comes a cycle with no request. Last comes a write cycle with `mem_req`=1, `mem_we`=1, `mem_addr` set to the destination and `mem_wdata` set to the byte read. After the move the source and destination addresses each rise by one and the count falls by one. A start accepted in cycle k gives its read cycle in cycle k+2.
- R4: In per-byte mode a channel makes exactly one byte move for each accepted start.
- R5: In block mode one accepted start makes the channel move all remaining bytes until its count is zero.
- R6: When interrupt start is enabled, a 0-to-1 change on the chosen line of `irq_in` is a start. Holding the line high gives no further starts, changes on other lines are ignored, and a channel with interrupt start disabled ignores all lines.
- R7: When several channels have work, the lowest channel number is served first. Arbitration repeats before every byte move, so a lower channel that starts mid-block gets the next move.
- R8: The cycle after the write cycle that brings a channel's count to zero, that channel's `done_pulse` bit is high for one cycle and its `done_flag` bit goes high and stays high. Only a write of the byte-count field of that channel clears the flag.
- R9: A start that arrives while the channel's count is zero is ignored: no memory cycle follows.
- R10: In per-byte mode, starts that arrive while the channel is being served are recorded as one pending start. Several such starts still yield only one further move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_fld | input | 3 | Field addressed by the write |
| cfg_wdata | input | 16 | Configuration write data |
| irq_in | input | 8 | Interrupt lines usable as starts |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |
| done_flag | output | 4 | Sticky per-channel completion flags |
| done_pulse | output | 4 | One-cycle per-channel completion pulses |

## Verification
A start taken at the end of cycle k gives an arbitration cycle k+1, the read in k+2, a quiet cycle in k+3, the write in k+4 and, for the last byte, the done pulse and flag in k+5. In block mode the next read follows four cycles after the previous one. The reference model updates on the same clock edge as the design and the outputs are compared half a period later, so every memory port signal and completion bit is checked in the exact cycle it is due. Scenario checks then read back the memory contents, count write cycles and compare the pulse cycle with the final write cycle, to cover the mode, priority, interrupt edge, ignored-start and pending-start rules.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_HOLD  = 2'd2,
        ENG_WRITE = 2'd3
    } eng_state_t;

    localparam int          FLD_W  = 3;
    localparam logic [2:0]  FLD_SRC  = 3'd0;
    localparam logic [2:0]  FLD_DST  = 3'd1;
    localparam logic [2:0]  FLD_CNT  = 3'd2;
    localparam logic [2:0]  FLD_CTRL = 3'd3;
    localparam logic [2:0]  FLD_KICK = 3'd4;

    localparam int CTRL_BLOCK   = 0;
    localparam int CTRL_IRQ_EN  = 1;
    localparam int CTRL_SEL_LSB = 2;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int IRQ_W  = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLD_W-1:0]  wr_fld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IRQ_W-1:0]  irq_rise,
    input  logic              grant,
    input  logic              step,
    output logic              req,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              done_flag,
    output logic              done_pulse
);

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q, cnt_after;
    logic              block_q, irq_en_q;
    logic [SEL_W-1:0]  sel_q;
    logic              pend_q, run_q;
    logic              flag_q, pulse_q;
    logic              trig, accept;

    // count as it stands once the current move (if any) has finished
    always_comb begin
        cnt_after = step ? cnt_q - 1'b1 : cnt_q;
    end

    always_comb begin
        trig   = (wr_en && (wr_fld == FLD_KICK)) || (irq_en_q && irq_rise[sel_q]);
        accept = trig && (cnt_after != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            block_q  <= 1'b0;
            irq_en_q <= 1'b0;
            sel_q    <= '0;
            pend_q   <= 1'b0;
            run_q    <= 1'b0;
            flag_q   <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (step) begin
                src_q <= src_q + 1'b1;
                dst_q <= dst_q + 1'b1;
                cnt_q <= cnt_after;
                if (cnt_after == '0) begin
                    flag_q  <= 1'b1;
                    pulse_q <= 1'b1;
                    run_q   <= 1'b0;
                    pend_q  <= 1'b0;
                end
            end
            if (grant) begin
                pend_q <= 1'b0;
            end
            if (accept) begin
                if (block_q) begin
                    run_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                end
            end
            if (wr_en) begin
                unique case (wr_fld)
                    FLD_SRC: src_q <= wr_data;
                    FLD_DST: dst_q <= wr_data;
                    FLD_CNT: begin
                        cnt_q  <= wr_data[CNT_W-1:0];
                        flag_q <= 1'b0;
                        pend_q <= 1'b0;
                        run_q  <= 1'b0;
                    end
                    FLD_CTRL: begin
                        block_q  <= wr_data[CTRL_BLOCK];
                        irq_en_q <= wr_data[CTRL_IRQ_EN];
                        sel_q    <= wr_data[CTRL_SEL_LSB +: SEL_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign req        = (pend_q || run_q) && (cnt_q != '0);
    assign src_addr   = src_q;
    assign dst_addr   = dst_q;
    assign done_flag  = flag_q;
    assign done_pulse = pulse_q;

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  win_idx
);

    // lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (req[k]) begin
                any     = 1'b1;
                win_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [7:0]        mem_rdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              grant_en,
    output logic              step_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    eng_state_t       state_q, state_d;
    logic [IDX_W-1:0] cur_q;
    logic [7:0]       byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            byte_q <= '0;
        end else begin
            if ((state_q == ENG_IDLE) && any_req) begin
                cur_q <= win_idx;
            end
            if (state_q == ENG_HOLD) begin
                byte_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (any_req) state_d = ENG_READ;
            ENG_READ:  state_d = ENG_HOLD;
            ENG_HOLD:  state_d = ENG_WRITE;
            ENG_WRITE: state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    always_comb begin
        grant_en  = 1'b0;
        step_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        unique case (state_q)
            ENG_IDLE:  grant_en = any_req;
            ENG_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
            end
            ENG_HOLD:  ;
            ENG_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_addr;
                step_en  = 1'b1;
            end
            default:   ;
        endcase
    end

    assign mem_wdata = byte_q;
    assign cur_idx   = cur_q;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int IRQ_W  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [(NUM_CH > 1 ? $clog2(NUM_CH) : 1)-1:0] cfg_ch,
    input  logic [2:0]                             cfg_fld,
    input  logic [ADDR_W-1:0]                      cfg_wdata,
    input  logic [IRQ_W-1:0]                       irq_in,
    output logic                                   mem_req,
    output logic                                   mem_we,
    output logic [ADDR_W-1:0]                      mem_addr,
    output logic [7:0]                             mem_wdata,
    input  logic [7:0]                             mem_rdata,
    output logic [NUM_CH-1:0]                      done_flag,
    output logic [NUM_CH-1:0]                      done_pulse
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SEL_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

    logic [IRQ_W-1:0]  irq_q, irq_rise;
    logic [NUM_CH-1:0] ch_req;
    logic [ADDR_W-1:0] src_arr [NUM_CH];
    logic [ADDR_W-1:0] dst_arr [NUM_CH];
    logic              any_req, grant_en, step_en;
    logic [IDX_W-1:0]  win_idx, cur_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_in;
        end
    end

    assign irq_rise = irq_in & ~irq_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .IRQ_W  (IRQ_W),
            .SEL_W  (SEL_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_we && (cfg_ch == IDX_W'(g))),
            .wr_fld     (cfg_fld),
            .wr_data    (cfg_wdata),
            .irq_rise   (irq_rise),
            .grant      (grant_en && (win_idx == IDX_W'(g))),
            .step       (step_en && (cur_idx == IDX_W'(g))),
            .req        (ch_req[g]),
            .src_addr   (src_arr[g]),
            .dst_addr   (dst_arr[g]),
            .done_flag  (done_flag[g]),
            .done_pulse (done_pulse[g])
        );
    end

    dma_arbiter #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_arb (
        .req     (ch_req),
        .any     (any_req),
        .win_idx (win_idx)
    );

    dma_engine #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req),
        .win_idx   (win_idx),
        .src_addr  (src_arr[cur_idx]),
        .dst_addr  (dst_arr[cur_idx]),
        .mem_rdata (mem_rdata),
        .cur_idx   (cur_idx),
        .grant_en  (grant_en),
        .step_en   (step_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [NUM_CH-1:0] done_flag,
    input logic [NUM_CH-1:0] done_pulse
);

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req) else $error("write enable without request"); // R3

    AST_GAP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req) else $error("no quiet cycle after read"); // R3

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> ##1 (mem_req && mem_we)) else $error("read not followed by write"); // R3

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse)) else $error("two done pulses at once"); // R8

    AST_PULSE_MARKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse & ~done_flag) == '0) else $error("pulse without flag"); // R8

    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse != '0) |-> $past(mem_req && mem_we)) else $error("pulse not after a write"); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ((done_flag & $past(done_flag)) == $past(done_flag))) else $error("flag dropped"); // R8

endmodule

bind dma_mover dma_mover_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .done_flag  (done_flag),
    .done_pulse (done_pulse)
);

// File: tb/test_dma_mover.sv
module test_dma_mover;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 8;
    localparam int IW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [2:0]     cfg_fld = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [IW-1:0]  irq_in = '0;
    logic           mem_req, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     mem_wdata;
    logic [7:0]     mem_rdata = '0;
    logic [NCH-1:0] done_flag, done_pulse;

    dma_mover #(.NUM_CH(NCH), .ADDR_W(AW), .CNT_W(CW), .IRQ_W(IW)) i_dma_mover (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld),
        .cfg_wdata(cfg_wdata), .irq_in(irq_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done_flag(done_flag), .done_pulse(done_pulse)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // memory seen by the design
    logic [7:0] ram [0:1023];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[9:0]];
        end
    end

    // behavioural reference model
    logic [7:0]    mref [0:1023];
    int            m_src [NCH], m_dst [NCH], m_cnt [NCH];
    bit            m_blkm [NCH], m_irqen [NCH], m_pend [NCH], m_run [NCH];
    bit            m_done [NCH], m_pulse [NCH];
    int            m_sel [NCH];
    int            m_st, m_cur, m_data, m_w;
    logic [IW-1:0] m_prev, m_rise;
    bit            m_trig;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cur = 0; m_data = 0; m_prev = '0;
            for (int k = 0; k < NCH; k++) begin
                m_src[k] = 0; m_dst[k] = 0; m_cnt[k] = 0; m_sel[k] = 0;
                m_blkm[k] = 0; m_irqen[k] = 0; m_pend[k] = 0; m_run[k] = 0;
                m_done[k] = 0; m_pulse[k] = 0;
            end
        end else begin
            m_rise = irq_in & ~m_prev;
            m_prev = irq_in;
            for (int k = 0; k < NCH; k++) m_pulse[k] = 0;
            case (m_st)
                0: begin
                    m_w = -1;
                    for (int k = NCH - 1; k >= 0; k--)
                        if ((m_pend[k] || m_run[k]) && m_cnt[k] != 0) m_w = k;
                    if (m_w >= 0) begin
                        m_cur = m_w; m_pend[m_w] = 0; m_st = 1;
                    end
                end
                1: begin m_data = mref[m_src[m_cur] & 1023]; m_st = 2; end
                2: m_st = 3;
                default: begin
                    mref[m_dst[m_cur] & 1023] = 8'(m_data);
                    m_src[m_cur] = (m_src[m_cur] + 1) & 16'hFFFF;
                    m_dst[m_cur] = (m_dst[m_cur] + 1) & 16'hFFFF;
                    m_cnt[m_cur] = m_cnt[m_cur] - 1;
                    if (m_cnt[m_cur] == 0) begin
                        m_done[m_cur] = 1; m_pulse[m_cur] = 1;
                        m_run[m_cur] = 0; m_pend[m_cur] = 0;
                    end
                    m_st = 0;
                end
            endcase
            for (int k = 0; k < NCH; k++) begin
                m_trig = (cfg_we && cfg_ch == 2'(k) && cfg_fld == 3'd4) ||
                         (m_irqen[k] && m_rise[m_sel[k]]);
                if (m_trig && m_cnt[k] != 0) begin
                    if (m_blkm[k]) m_run[k] = 1; else m_pend[k] = 1;
                end
            end
            if (cfg_we) begin
                case (cfg_fld)
                    3'd0: m_src[cfg_ch] = int'(cfg_wdata);
                    3'd1: m_dst[cfg_ch] = int'(cfg_wdata);
                    3'd2: begin
                        m_cnt[cfg_ch] = int'(cfg_wdata[7:0]);
                        m_done[cfg_ch] = 0; m_pend[cfg_ch] = 0; m_run[cfg_ch] = 0;
                    end
                    3'd3: begin
                        m_blkm[cfg_ch] = cfg_wdata[0];
                        m_irqen[cfg_ch] = cfg_wdata[1];
                        m_sel[cfg_ch] = int'(cfg_wdata[4:2]);
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and event recording, away from the active edge
    int cyc = 0;
    int wr_cnt = 0;
    int last_wr = 0;
    int pcyc [NCH];
    int first_wr_addr = -1;
    logic [NCH-1:0] e_flag, e_pulse;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                e_flag[k] = m_done[k]; e_pulse[k] = m_pulse[k];
            end
            chk(mem_req == (m_st == 1 || m_st == 3), "R3 mem_req", int'(mem_req), int'(m_st == 1 || m_st == 3));
            chk(mem_we == (m_st == 3), "R3 mem_we", int'(mem_we), int'(m_st == 3));
            if (m_st == 1) chk(int'(mem_addr) == m_src[m_cur], "R3 read address", int'(mem_addr), m_src[m_cur]);
            if (m_st == 3) begin
                chk(int'(mem_addr) == m_dst[m_cur], "R3 write address", int'(mem_addr), m_dst[m_cur]);
                chk(int'(mem_wdata) == m_data, "R3 write data", int'(mem_wdata), m_data);
            end
            chk(done_flag == e_flag, "R8 done_flag", int'(done_flag), int'(e_flag));
            chk(done_pulse == e_pulse, "R8 done_pulse", int'(done_pulse), int'(e_pulse));
            if (mem_req && mem_we) begin
                wr_cnt++;
                last_wr = cyc;
                if (first_wr_addr < 0) first_wr_addr = int'(mem_addr);
            end
            for (int k = 0; k < NCH; k++) if (done_pulse[k]) pcyc[k] = cyc;
        end
    end

    task automatic wr(input int ch, input int fld, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_fld = 3'(fld); cfg_wdata = AW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int ch, input int s, input int d, input int n, input int ctrl);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 3, ctrl); wr(ch, 2, n);
    endtask

    int base;

    initial begin
        for (int a = 0; a < 1024; a++) begin
            ram[a] = pat(a); mref[a] = pat(a);
        end
        for (int k = 0; k < NCH; k++) pcyc[k] = 0;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(mem_req == 1'b0 && mem_we == 1'b0, "R1 port idle", int'({mem_req, mem_we}), 0);
        chk(done_flag == '0 && done_pulse == '0, "R1 done clear", int'({done_flag, done_pulse}), 0);
        idle(4);
        chk(wr_cnt == 0, "R1 no work after reset", wr_cnt, 0);

        // per-byte mode, channel 0
        setup(0, 'h10, 'h100, 3, 0);
        wr(0, 4, 0); idle(8);
        chk(ram['h100] == pat('h10), "R2 source/destination fields", int'(ram['h100]), int'(pat('h10)));
        chk(wr_cnt == 1, "R4 one byte per start", wr_cnt, 1);
        chk(ram['h101] == pat('h101), "R4 next byte untouched", int'(ram['h101]), int'(pat('h101)));
        chk(done_flag[0] == 1'b0, "R8 flag low mid-block", int'(done_flag[0]), 0);
        wr(0, 4, 0); idle(8);
        wr(0, 4, 0); idle(8);
        chk(ram['h102] == pat('h12), "R3 addresses advanced", int'(ram['h102]), int'(pat('h12)));
        chk(done_flag[0] == 1'b1, "R8 flag set at zero", int'(done_flag[0]), 1);
        chk(pcyc[0] == last_wr + 1, "R8 pulse the cycle after last write", pcyc[0], last_wr + 1);
        // start at zero count
        wr(0, 4, 0); idle(8);
        chk(wr_cnt == 3, "R9 start ignored at zero", wr_cnt, 3);
        chk(ram['h103] == pat('h103), "R9 memory untouched", int'(ram['h103]), int'(pat('h103)));
        chk(done_flag[0] == 1'b1, "R8 flag sticky", int'(done_flag[0]), 1);

        // block mode, channel 1
        base = wr_cnt;
        setup(1, 'h20, 'h120, 5, 1);
        wr(1, 4, 0); idle(30);
        chk(wr_cnt - base == 5, "R5 whole block on one start", wr_cnt - base, 5);
        chk(ram['h124] == pat('h24), "R5 last byte", int'(ram['h124]), int'(pat('h24)));
        chk(done_flag[1] == 1'b1, "R5 block done", int'(done_flag[1]), 1);

        // priority, channels 3 then 2
        setup(3, 'h40, 'h140, 4, 1);
        setup(2, 'h50, 'h150, 4, 1);
        first_wr_addr = -1;
        wr(3, 4, 0);
        wr(2, 4, 0);
        idle(50);
        chk(first_wr_addr == 'h140, "R7 running channel first byte", first_wr_addr, 'h140);
        chk(pcyc[2] < pcyc[3], "R7 lower channel finishes first", pcyc[2], pcyc[3]);
        chk(ram['h153] == pat('h53) && ram['h143] == pat('h43), "R7 both blocks copied",
            int'(ram['h153]), int'(pat('h53)));

        // interrupt starts
        setup(0, 'h60, 'h160, 2, 'h16);
        setup(1, 'h70, 'h170, 3, 'h15);
        chk(done_flag[0] == 1'b0, "R8 count write clears flag", int'(done_flag[0]), 0);
        base = wr_cnt;
        @(negedge clk); irq_in[4] = 1'b1; idle(8);
        chk(wr_cnt == base, "R6 other line ignored", wr_cnt - base, 0);
        @(negedge clk); irq_in[5] = 1'b1; idle(8);
        chk(wr_cnt - base == 1, "R6 rising edge starts", wr_cnt - base, 1);
        idle(8);
        chk(wr_cnt - base == 1, "R6 held level no restart", wr_cnt - base, 1);
        @(negedge clk); irq_in[5] = 1'b0; idle(2);
        @(negedge clk); irq_in[5] = 1'b1; idle(8);
        chk(wr_cnt - base == 2 && done_flag[0], "R6 second edge finishes", wr_cnt - base, 2);
        chk(ram['h170] == pat('h170) && !done_flag[1], "R6 disabled channel idle",
            int'(ram['h170]), int'(pat('h170)));
        irq_in = '0;
        idle(2);

        // pending start while busy
        base = wr_cnt;
        setup(2, 'h80, 'h180, 4, 0);
        wr(2, 4, 0); wr(2, 4, 0); wr(2, 4, 0);
        idle(16);
        chk(wr_cnt - base == 2, "R10 starts while busy collapse to one", wr_cnt - base, 2);
        chk(done_flag[2] == 1'b0, "R10 count not exhausted", int'(done_flag[2]), 0);
        wr(2, 4, 0); idle(8); wr(2, 4, 0); idle(8);
        chk(done_flag[2] == 1'b1 && ram['h183] == pat('h83), "R10 remaining bytes on later starts",
            int'(ram['h183]), int'(pat('h83)));

        for (int a = 0; a < 1024; a++)
            if (ram[a] !== mref[a]) chk(1'b0, "R3 memory image", a, int'(mref[a]));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule